// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

This block is an eight-bit general-purpose I/O port. A processor reaches it through a small register interface. That interface offers four operations: load the output latch, load the direction register, set or clear one latch bit, and read the port. Each pin drives its pad through a tri-state driver, which is given here as a value output and an enable output. The pad level comes back on a separate input.

Each pin also connects to an on-chip peripheral. The peripheral can take over the driver with its own enable and value. This override wins over the direction bit. The synchronised pad level goes to the peripheral's input tap at all times.

A port read returns the synchronised pad level, not the latch. Single-bit set and clear operations work on the latch itself, so a pin whose pad level differs from the latch cannot corrupt the other latch bits. Reset clears the direction register but leaves the output latch alone. Software therefore loads the latch before it turns a pin into an output.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low, `dir_q` is 0 and `pad_oe` equals `per_oe`, so every pin without a peripheral override is high-impedance.
- R2: A pin with `dir_q[i]`=1 and `per_oe[i]`=0 has `pad_oe[i]`=1 and `pad_out[i]` equal to latch bit i.
- R3: A pin with `dir_q[i]`=0 and `per_oe[i]`=0 has `pad_oe[i]`=0.
- R4: A `bus_wr` pulse loads `wdata` into the latch whatever the direction bits are. The new value appears on `pad_out` for the pins that are outputs from the next cycle on.
- R5: `rd_data` equals the value `pad_in` had two rising clock edges earlier, in both input and output mode.
- R6: A `bus_bitop` pulse without `bus_wr` writes `bitop_set` into latch bit `bitop_idx`. The new bit value is `bitop_set`: 1 sets the bit, 0 clears it. All other latch bits keep their latch values, whatever the pad levels are.
- R7: With `per_oe[i]`=1, `pad_oe[i]`=1 and `pad_out[i]`=`per_out[i]`, regardless of `dir_q[i]`.
- R8: `per_in` always equals `rd_data`, independent of the direction and override settings.
- R9: Reset does not change the output latch. A value written before reset is driven again once a pin is made an output after reset.
- R10: When `bus_wr` and `bus_bitop` are high in the same cycle, the latch takes `wdata` and the bit operation is dropped.
- R11: A `bus_dir_wr` pulse loads `wdata` into `dir_q` at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Load output latch from `wdata` |
| bus_dir_wr | input | 1 | Load direction register from `wdata` |
| bus_bitop | input | 1 | Single-bit latch operation |
| bitop_set | input | 1 | Value for the bit operation (1 set, 0 clear) |
| bitop_idx | input | 3 | Bit index for the bit operation |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Synchronised pad levels (port read) |
| dir_q | output | 8 | Direction register, 1 = output |
| pad_out | output | 8 | Driver value per pin |
| pad_oe | output | 8 | Driver enable per pin |
| pad_in | input | 8 | Pad levels |
| per_out | input | 8 | Peripheral output value |
| per_oe | input | 8 | Peripheral output enable |
| per_in | output | 8 | Peripheral input tap |

## Verification
The bench drives input pins whose pad levels oppose the latch and then issues bit operations. A design that built its read-modify-write from the pad level would flip neighbouring latch bits, and this shows up once the pins become outputs. Peripheral overrides are applied while the direction bit is 0. Reset pulses are placed after latch writes to catch a latch that clears, and a write collides with a bit operation in the same cycle to catch the wrong priority. The model also tracks the two-edge read-back lag, so a synchroniser with one stage or three gives a mismatch on every pad change.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_dir_wr,
  input  logic          bus_bitop,
  input  logic          bitop_set,
  input  logic [IW-1:0] bitop_idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  input  logic [W-1:0]  pad_in,
  input  logic [W-1:0]  per_out,
  input  logic [W-1:0]  per_oe,
  output logic [W-1:0]  per_in
);

  logic [W-1:0] lat;
  logic [W-1:0] sync1, sync2;

  always_ff @(posedge clk) begin
    if (bus_wr)
      lat <= wdata;
    else if (bus_bitop)
      lat[bitop_idx] <= bitop_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      if (bus_dir_wr) dir_q <= wdata;
      sync1 <= pad_in;
      sync2 <= sync1;
    end
  end

  assign pad_oe  = dir_q | per_oe;
  assign pad_out = (per_oe & per_out) | (~per_oe & lat);
  assign rd_data = sync2;
  assign per_in  = sync2;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_dir_wr,
  input logic          bus_bitop,
  input logic          bitop_set,
  input logic [IW-1:0] bitop_idx,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  lat,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  pad_in,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  per_oe,
  input logic [W-1:0]  per_out,
  input logic [W-1:0]  per_in,
  input logic [W-1:0]  rd_data
);

  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  p_reset_dir_r1: assert property (@(posedge clk) !rst_n |-> (dir_q == '0 && pad_oe == per_oe));

  p_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~dir_q & ~per_oe) == '0));

  p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & per_oe) == per_oe) && ((pad_out & per_oe) == (per_out & per_oe)));

  p_sync_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2) |-> (rd_data == $past(pad_in, 2)));

  p_tap_r8: assert property (@(posedge clk) disable iff (!rst_n) per_in == rd_data);

  p_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (lat == $past(wdata)));

  p_bitop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_bitop && !bus_wr) |=> (lat[$past(bitop_idx)] == $past(bitop_set)));

  p_dir_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dir_wr |=> (dir_q == $past(wdata)));

endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_dir_wr(bus_dir_wr),
  .bus_bitop(bus_bitop), .bitop_set(bitop_set), .bitop_idx(bitop_idx),
  .wdata(wdata), .lat(lat), .dir_q(dir_q), .pad_in(pad_in), .pad_oe(pad_oe),
  .pad_out(pad_out), .per_oe(per_oe), .per_out(per_out), .per_in(per_in),
  .rd_data(rd_data)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_dir_wr = 1'b0, bus_bitop = 1'b0, bitop_set = 1'b0;
  logic [2:0] bitop_idx = '0;
  logic [7:0] wdata = '0, pad_in = '0, per_out = '0, per_oe = '0, ext = '0;
  logic [7:0] rd_data, dir_q, pad_out, pad_oe, per_in;

  int vec = 0, bad = 0;
  bit done = 0;

  logic [7:0] m_dir = '0, m_lat = '0, m_known = '0, m_s1 = '0, m_s2 = '0;

  always #4 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_dir_wr(bus_dir_wr),
    .bus_bitop(bus_bitop), .bitop_set(bitop_set), .bitop_idx(bitop_idx),
    .wdata(wdata), .rd_data(rd_data), .dir_q(dir_q), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_in(pad_in), .per_out(per_out), .per_oe(per_oe),
    .per_in(per_in)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = '0; m_s1 = '0; m_s2 = '0;
    end else begin
      if (bus_dir_wr) m_dir = wdata;
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
    if (bus_wr) begin
      m_lat = wdata; m_known = 8'hFF;
    end else if (bus_bitop) begin
      m_lat[bitop_idx] = bitop_set; m_known[bitop_idx] = 1'b1;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e_oe, e_out, msk;
    e_oe  = m_dir | per_oe;
    e_out = (per_oe & per_out) | (~per_oe & m_lat);
    msk   = e_oe & (per_oe | m_known);
    check(!rst_n ? "R1" : "R11", dir_q, m_dir);
    check(per_oe != 0 ? "R7" : (m_dir != 0 ? "R2" : "R3"), pad_oe, e_oe);
    check(per_oe != 0 ? "R7" : "R2", pad_out & msk, e_out & msk);
    check("R5", rd_data, m_s2);
    check("R8", per_in, m_s2);
  endtask

  task automatic cyc();
    #1 pad_in = (pad_oe & pad_out) | (~pad_oe & ext);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    bus_wr = 0; bus_dir_wr = 0; bus_bitop = 0;
  endtask

  initial begin
    repeat (3) cyc();
    check("R1", pad_oe, 8'h00);
    rst_n = 1;
    cyc();

    // R4: write with all pins inputs, then enable outputs
    ext = 8'hC3;
    bus_wr = 1; wdata = 8'h3C; cyc(); idle();
    check("R3", pad_oe, 8'h00);
    bus_dir_wr = 1; wdata = 8'hFF; cyc(); idle();
    check("R4", pad_out, 8'h3C);

    // R6: pads oppose latch, bit set uses latch
    bus_dir_wr = 1; wdata = 8'h00; cyc(); idle();
    bus_wr = 1; wdata = 8'h00; ext = 8'hFF; cyc(); idle();
    repeat (2) cyc();
    check("R5", rd_data, 8'hFF);
    bus_bitop = 1; bitop_set = 1; bitop_idx = 3'd3; cyc(); idle();
    bus_dir_wr = 1; wdata = 8'hFF; cyc(); idle();
    check("R6", pad_out, 8'h08);
    bus_dir_wr = 1; wdata = 8'h00; ext = 8'h00; cyc(); idle();
    bus_wr = 1; wdata = 8'hFF; cyc(); idle();
    bus_bitop = 1; bitop_set = 0; bitop_idx = 3'd6; cyc(); idle();
    bus_dir_wr = 1; wdata = 8'hFF; cyc(); idle();
    check("R6", pad_out, 8'hBF);

    // R10: write beats bit op
    bus_wr = 1; wdata = 8'h55; bus_bitop = 1; bitop_set = 1; bitop_idx = 3'd1; cyc(); idle();
    check("R10", pad_out, 8'h55);

    // R7: override with direction 0
    bus_dir_wr = 1; wdata = 8'h00; cyc(); idle();
    per_oe = 8'h0F; per_out = 8'h0A; cyc();
    check("R7", pad_oe, 8'h0F);
    check("R7", pad_out & 8'h0F, 8'h0A);
    repeat (2) cyc();
    check("R8", per_in & 8'h0F, 8'h0A);
    per_oe = 0;

    // R9: latch survives reset
    bus_wr = 1; wdata = 8'hA6; cyc(); idle();
    rst_n = 0; cyc(); cyc();
    check("R1", dir_q, 8'h00);
    rst_n = 1; cyc();
    bus_dir_wr = 1; wdata = 8'hFF; cyc(); idle();
    check("R9", pad_out, 8'hA6);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bus_wr     = ($urandom % 8) == 0;
      bus_dir_wr = ($urandom % 10) == 0;
      bus_bitop  = ($urandom % 4) == 0;
      bitop_set  = $urandom;
      bitop_idx  = $urandom;
      wdata      = $urandom;
      ext        = ($urandom % 3 == 0) ? 8'($urandom) : ext;
      per_oe     = ($urandom % 5 == 0) ? 8'($urandom) : per_oe;
      per_out    = $urandom;
      rst_n      = ($urandom % 300) != 0;
      cyc();
    end
    idle(); rst_n = 1;
    cyc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule